// File: doc/BRIEF.md
# Serial BCD Real-Time Clock Register File

This block is the device side of a small real-time clock. It keeps seconds, minutes, hours, day of month, month, weekday and a two-digit year as packed BCD, and it advances them by one second on every pulse of a one-second tick input. A host reaches the registers over a three-wire serial link: a chip enable, a serial clock and a data line, with the data split here into an input and an output plus an output-enable for the pad. A write-protect flag, a halt flag that stops timekeeping, a charger configuration byte and a scratch RAM complete the register set.

Each transaction opens with a command byte. The command carries the register address and the transfer direction, and is followed either by data bytes from the host or by data bytes that the block returns. Address 0x1F selects a burst transfer that covers all eight clock registers in one transaction. The serial inputs must be synchronous to `clk`, and each serial clock level must last at least two `clk` cycles. A write commits only when its eighth data bit arrives, so a transaction cut short never leaves a half-written register.

Top module: `rtc_bcd_serial`

## Requirements
- R1: A transaction runs while `ser_ce` is high. Bits are sampled on rising edges of `ser_clk`, least significant bit first. The command byte is valid only when bit 7 is 1, and it then gives address = bits 6:1 and read = bit 0. If bit 7 is 0, everything up to the next drop of `ser_ce` is ignored.
- R2: On a read, each returned bit appears on `ser_dout` after a falling edge of `ser_clk`, least significant bit first, starting at the first falling edge after the command. `ser_dout_en` is high while that read runs and low once `ser_ce` is low.
- R3: Register addresses: seconds 0x00, minutes 0x01, hours 0x02, date 0x03, month 0x04, weekday 0x05, year 0x06, control 0x07, charger 0x08. Unmapped addresses read as 0x00.
- R4: Control bit 7 is write-protect and is 1 after reset. Control bits 6:0 always read as 0. Control can be written even while write-protect is set.
- R5: While write-protect is set, writes to every other register, the scratch RAM included, are ignored.
- R6: Seconds bit 7 is the halt flag, and it is 1 after reset (seconds reads 0x80). While it is set, ticks change nothing. The other seconds bits stay writable.
- R7: With halt clear, each tick increments seconds 00..59. Seconds carries into minutes 00..59, and minutes carries into hours 00..23, all in BCD.
- R8: A carry out of hours increments the date up to the month's length (30 for April, June, September and November; 28 for February, or 29 when the year is a multiple of 4; 31 otherwise) and then wraps to 01. A date wrap increments the month 01..12, and a month wrap increments the year 00..99.
- R9: The weekday, 1..7, advances with every date increment and wraps from 7 to 1.
- R10: A write to 0x1F takes eight data bytes in the order seconds, minutes, hours, date, month, weekday, year, control.
- R11: A read from 0x1F returns the eight clock registers from seconds through control, one byte per eight serial clocks.
- R12: The charger register reads back as written. `charge_en` is 1 only when its upper nibble is 0xA. `charge_sel` shows the lower nibble while `charge_en` is 1 and is 0 otherwise.
- R13: Dropping `ser_ce` in the middle of a byte abandons the transaction, discards the partial byte and resets the bit count, so the next transaction starts cleanly.
- R14: Scratch RAM occupies 0x20 through 0x20+RAM_DEPTH-1 and is readable and writable per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ser_ce | input | 1 | Serial transaction enable |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_dout_en | output | 1 | Drive enable for the data pad |
| charge_en | output | 1 | Charger enabled by the configuration pattern |
| charge_sel | output | 4 | Charger selection bits, zero when disabled |

## Verification
The bench sweeps every seconds value across a tick, every month boundary, and all hundred years at the end of February. A wrong BCD carry would show up as 0x0A or a missed minute. A wrong month-length table would roll 30-day months on day 31, and a wrong leap rule would land the day after 28 February on 0x29 in the wrong years or never reach it. It writes under write-protect to a time register, to RAM and to the charger, and expects no change at all, so a gate that covers only some targets is caught. It also sends a truncated byte and a command with bit 7 clear, then reads the target back: a design that committed partial shifts or kept a stale bit count would corrupt the register or misread the next command.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_SEC     = 6'h00;
  localparam logic [ADDR_W-1:0] A_MIN     = 6'h01;
  localparam logic [ADDR_W-1:0] A_HOUR    = 6'h02;
  localparam logic [ADDR_W-1:0] A_DATE    = 6'h03;
  localparam logic [ADDR_W-1:0] A_MONTH   = 6'h04;
  localparam logic [ADDR_W-1:0] A_WDAY    = 6'h05;
  localparam logic [ADDR_W-1:0] A_YEAR    = 6'h06;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h07;
  localparam logic [ADDR_W-1:0] A_CHARGE  = 6'h08;
  localparam logic [ADDR_W-1:0] A_BURST   = 6'h1F;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_SKIP} ser_phase_e;

  // Increment a packed two-digit BCD byte (no range wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month; year multiple of four counts as leap.
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ser_port.sv
module rtc_ser_port
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sclk,
  input  logic              din,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              dout,
  output logic              dout_en
);
  localparam int BURST_N = 8;
  localparam int IDX_W   = $clog2(BURST_N);

  ser_phase_e        phase;
  logic              sclk_q;
  logic [2:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        byte_q;
  logic [ADDR_W-1:0] addr_q;
  logic              burst_q;
  logic [IDX_W-1:0]  idx;
  logic              rise, fall;
  logic [7:0]        in_byte;
  logic [ADDR_W-1:0] cur_addr;

  assign rise     = ce && sclk && !sclk_q;
  assign fall     = ce && !sclk && sclk_q;
  assign in_byte  = {din, shreg[7:1]};
  assign cur_addr = burst_q ? ADDR_W'(idx) : addr_q;
  assign rd_addr  = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      sclk_q  <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      byte_q  <= '0;
      addr_q  <= '0;
      burst_q <= 1'b0;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      sclk_q <= sclk;
      wr_en  <= 1'b0;
      if (!ce) begin
        phase   <= PH_CMD;
        bitcnt  <= '0;
        dout    <= 1'b0;
        dout_en <= 1'b0;
      end else begin
        if (rise) begin
          shreg  <= in_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            unique case (phase)
              PH_CMD: begin
                idx     <= '0;
                addr_q  <= in_byte[6:1];
                burst_q <= (in_byte[6:1] == A_BURST);
                if (!in_byte[7])     phase <= PH_SKIP;
                else if (in_byte[0]) phase <= PH_RD;
                else                 phase <= PH_WR;
              end
              PH_WR: begin
                wr_en   <= 1'b1;
                wr_addr <= cur_addr;
                wr_data <= in_byte;
                idx     <= idx + 1'b1;
                if (!burst_q || idx == IDX_W'(BURST_N - 1)) phase <= PH_SKIP;
              end
              PH_RD:   if (burst_q) idx <= idx + 1'b1;
              PH_SKIP: ;
            endcase
          end
        end
        if (fall && phase == PH_RD) begin
          dout_en <= 1'b1;
          if (bitcnt == 3'd0) begin
            byte_q <= rdata;
            dout   <= rdata[0];
          end else begin
            dout   <= byte_q[bitcnt];
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              wp,
  output logic [7:0]        sec_q,
  output logic [7:0]        min_q,
  output logic              charge_en,
  output logic [3:0]        charge_sel
);
  logic [7:0] hour_q, date_q, mon_q, wday_q, year_q, chg_q;
  logic       wr_ok, time_wr;
  logic       c_sec, c_min, c_hour, c_date, c_mon;
  logic [7:0] n_sec, n_min, n_hour, n_date, n_mon, n_wday, n_year;

  assign wr_ok   = wr_en && (wr_addr == A_CTRL || !wp);
  assign time_wr = wr_ok && (wr_addr <= A_YEAR);

  always_comb begin
    c_sec  = (sec_q[6:0] == 7'h59);
    c_min  = c_sec  && (min_q  == 8'h59);
    c_hour = c_min  && (hour_q == 8'h23);
    c_date = c_hour && (date_q == month_last(mon_q, year_q));
    c_mon  = c_date && (mon_q  == 8'h12);
    n_sec  = {sec_q[7], c_sec ? 7'h00 : bcd_inc({1'b0, sec_q[6:0]})[6:0]};
    n_min  = c_sec  ? (c_min  ? 8'h00 : bcd_inc(min_q))  : min_q;
    n_hour = c_min  ? (c_hour ? 8'h00 : bcd_inc(hour_q)) : hour_q;
    n_date = c_hour ? (c_date ? 8'h01 : bcd_inc(date_q)) : date_q;
    n_mon  = c_date ? (c_mon  ? 8'h01 : bcd_inc(mon_q))  : mon_q;
    n_year = c_mon  ? ((year_q == 8'h99) ? 8'h00 : bcd_inc(year_q)) : year_q;
    n_wday = c_hour ? ((wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01) : wday_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h80;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      wday_q <= 8'h01;
      year_q <= 8'h00;
      wp     <= 1'b1;
      chg_q  <= 8'h00;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          A_SEC:    sec_q  <= wr_data;
          A_MIN:    min_q  <= {1'b0, wr_data[6:0]};
          A_HOUR:   hour_q <= {2'b0, wr_data[5:0]};
          A_DATE:   date_q <= {2'b0, wr_data[5:0]};
          A_MONTH:  mon_q  <= {3'b0, wr_data[4:0]};
          A_WDAY:   wday_q <= {5'b0, wr_data[2:0]};
          A_YEAR:   year_q <= wr_data;
          A_CTRL:   wp     <= wr_data[7];
          A_CHARGE: chg_q  <= wr_data;
          default: ;
        endcase
      end
      if (tick && !sec_q[7] && !time_wr) begin
        sec_q  <= n_sec;
        min_q  <= n_min;
        hour_q <= n_hour;
        date_q <= n_date;
        mon_q  <= n_mon;
        wday_q <= n_wday;
        year_q <= n_year;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      charge_en  <= 1'b0;
      charge_sel <= 4'h0;
    end else begin
      charge_en  <= (chg_q[7:4] == 4'hA);
      charge_sel <= (chg_q[7:4] == 4'hA) ? chg_q[3:0] : 4'h0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_SEC:    rd_byte = sec_q;
      A_MIN:    rd_byte = min_q;
      A_HOUR:   rd_byte = hour_q;
      A_DATE:   rd_byte = date_q;
      A_MONTH:  rd_byte = mon_q;
      A_WDAY:   rd_byte = wday_q;
      A_YEAR:   rd_byte = year_q;
      A_CTRL:   rd_byte = {wp, 7'b0};
      A_CHARGE: rd_byte = chg_q;
      default:  rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int DEPTH = 31,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtc_bcd_serial.sv
module rtc_bcd_serial
  import rtc_bcd_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       ser_ce,
  input  logic       ser_clk,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       ser_dout_en,
  output logic       charge_en,
  output logic [3:0] charge_sel
);
  localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en, wp;
  logic [7:0]        wr_data, tk_byte, ram_q, rdata;
  logic [7:0]        sec_q, min_q;
  logic              ram_wr_hit, ram_rd_hit, ram_sel_q;

  assign ram_wr_hit = wr_addr[5] && (int'(wr_addr[4:0]) < RAM_DEPTH);
  assign ram_rd_hit = rd_addr[5] && (int'(rd_addr[4:0]) < RAM_DEPTH);
  assign rdata      = ram_sel_q ? ram_q : tk_byte;

  always_ff @(posedge clk) begin
    if (rst) ram_sel_q <= 1'b0;
    else     ram_sel_q <= ram_rd_hit;
  end

  rtc_ser_port u_port (
    .clk     (clk),
    .rst     (rst),
    .ce      (ser_ce),
    .sclk    (ser_clk),
    .din     (ser_din),
    .rdata   (rdata),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dout    (ser_dout),
    .dout_en (ser_dout_en)
  );

  rtc_timekeeper u_time (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_1hz),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_byte    (tk_byte),
    .wp         (wp),
    .sec_q      (sec_q),
    .min_q      (min_q),
    .charge_en  (charge_en),
    .charge_sel (charge_sel)
  );

  rtc_scratch_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (wr_en && !wp && ram_wr_hit),
    .waddr (wr_addr[RAM_AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_addr[RAM_AW-1:0]),
    .rdata (ram_q)
  );
endmodule

// File: rtl/rtc_bcd_serial_chk.sv
module rtc_bcd_serial_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       ser_ce,
  input logic       ser_dout_en,
  input logic       wr_en,
  input logic [5:0] wr_addr,
  input logic       wp,
  input logic [7:0] sec_q,
  input logic [7:0] min_q
);
  assert_dout_off_R2: assert property (@(posedge clk) disable iff (rst)
    !ser_ce |=> !ser_dout_en);

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    sec_q[7] && !wr_en |=> $stable(sec_q));

  assert_wp_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    wp && wr_en && wr_addr == 6'h01 && !tick_1hz |=> $stable(min_q));

  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    tick_1hz && !sec_q[7] && sec_q[6:0] == 7'h59 && !wr_en |=> sec_q[6:0] == 7'h00);

  assert_sec_digit_R7: assert property (@(posedge clk) disable iff (rst)
    sec_q[3:0] <= 4'd9);
endmodule

bind rtc_bcd_serial rtc_bcd_serial_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_1hz    (tick_1hz),
  .ser_ce      (ser_ce),
  .ser_dout_en (ser_dout_en),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wp          (wp),
  .sec_q       (sec_q),
  .min_q       (min_q)
);

// File: tb/test_rtc_bcd_serial.sv
`timescale 1ns/1ps
module test_rtc_bcd_serial;
  localparam int RAM_DEPTH = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_dout_en, charge_en;
  logic [3:0] charge_sel;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_bcd_serial #(.RAM_DEPTH(RAM_DEPTH)) i_rtc_bcd_serial (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .ser_ce(ser_ce),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .charge_en(charge_en), .charge_sel(charge_sel)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tx_begin();
    @(negedge clk); ser_clk = 1'b0; ser_ce = 1'b1; wait_n(2);
  endtask

  task automatic tx_end();
    @(negedge clk); ser_ce = 1'b0; ser_clk = 1'b0; wait_n(3);
  endtask

  task automatic send_bit(input logic b);
    ser_clk = 1'b0; ser_din = b; wait_n(2);
    ser_clk = 1'b1; wait_n(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      ser_clk = 1'b0; wait_n(2);
      v[i] = ser_dout;
      ser_clk = 1'b1; wait_n(2);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] v);
    tx_begin(); send_byte({1'b1, a, 1'b0}); send_byte(v); tx_end();
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
    tx_begin(); send_byte({1'b1, a, 1'b1}); recv_byte(v); tx_end();
  endtask

  task automatic burst_wr(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w,
                          input logic [7:0] y);
    tx_begin(); send_byte(8'hBE);
    send_byte(s); send_byte(m); send_byte(h); send_byte(d);
    send_byte(mo); send_byte(w); send_byte(y); send_byte(8'h00);
    tx_end();
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; wait_n(2);
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] bv [8];
    wait_n(4); rst = 1'b0; wait_n(3);

    // Reset state
    check("R2 dout_en idle", int'(ser_dout_en), 0);
    rd_reg(6'h07, v); check("R4 ctrl reset", v, 8'h80);
    rd_reg(6'h00, v); check("R6 sec reset halted", v, 8'h80);
    rd_reg(6'h0A, v); check("R3 unmapped reads zero", v, 8'h00);

    // R4: control writable under protect, low bits read zero
    wr_reg(6'h07, 8'h7F); rd_reg(6'h07, v); check("R4 ctrl low bits", v, 8'h00);

    // R14: RAM sweep
    for (int i = 0; i < RAM_DEPTH; i++) wr_reg(6'(32 + i), 8'((i * 37 + 5) & 255));
    for (int i = 0; i < RAM_DEPTH; i++) begin
      rd_reg(6'(32 + i), v); check("R14 ram", v, (i * 37 + 5) & 255);
    end

    // R1/R13: valid write, then aborted and invalid commands leave it
    wr_reg(6'h01, 8'h22); rd_reg(6'h01, v); check("R3 min write", v, 8'h22);
    tx_begin(); send_byte(8'h82); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); tx_end();
    rd_reg(6'h01, v); check("R13 abort discards", v, 8'h22);
    wr_reg(6'h01, 8'h31); rd_reg(6'h01, v); check("R13 clean restart", v, 8'h31);
    tx_begin(); send_byte(8'h02); send_byte(8'h44); tx_end();
    rd_reg(6'h01, v); check("R1 bit7 clear ignored", v, 8'h31);

    // R12: charger
    wr_reg(6'h08, 8'hA5); wait_n(3);
    check("R12 charge_en", int'(charge_en), 1); check("R12 charge_sel", int'(charge_sel), 5);
    wr_reg(6'h08, 8'h95); wait_n(3);
    check("R12 charge off", int'(charge_en), 0); check("R12 sel off", int'(charge_sel), 0);
    rd_reg(6'h08, v); check("R12 readback", v, 8'h95);

    // R5: write-protect
    wr_reg(6'h07, 8'h80);
    wr_reg(6'h01, 8'h47); wr_reg(6'h21, 8'hEE); wr_reg(6'h08, 8'hA3); wait_n(3);
    rd_reg(6'h01, v); check("R5 min protected", v, 8'h31);
    rd_reg(6'h21, v); check("R5 ram protected", v, (1 * 37 + 5) & 255);
    rd_reg(6'h08, v); check("R5 charger protected", v, 8'h95);
    check("R5 charge_en unchanged", int'(charge_en), 0);
    wr_reg(6'h07, 8'h00); rd_reg(6'h07, v); check("R4 ctrl cleared", v, 8'h00);

    // R6: halt
    wr_reg(6'h00, 8'h85);
    pulse_tick(); pulse_tick(); pulse_tick();
    rd_reg(6'h00, v); check("R6 halted frozen", v, 8'h85);
    wr_reg(6'h00, 8'h05); pulse_tick();
    rd_reg(6'h00, v); check("R6 resumed", v, 8'h06);

    // R7: seconds sweep with minute carry
    for (int s = 0; s < 60; s++) begin
      wr_reg(6'h01, 8'h10); wr_reg(6'h00, to_bcd(s)); pulse_tick();
      rd_reg(6'h00, v); check("R7 sec inc", v, to_bcd((s + 1) % 60));
      rd_reg(6'h01, v); check("R7 min carry", v, (s == 59) ? 8'h11 : 8'h10);
    end
    wr_reg(6'h02, 8'h09); wr_reg(6'h01, 8'h59); wr_reg(6'h00, 8'h59); pulse_tick();
    rd_reg(6'h02, v); check("R7 hour bcd carry", v, 8'h10);

    // R8/R10/R11/R9: month boundary sweep through bursts
    for (int m = 1; m <= 12; m++) begin
      burst_wr(8'h59, 8'h59, 8'h23, to_bcd(days_in(m, 21)), to_bcd(m), 8'h07, 8'h21);
      pulse_tick();
      tx_begin(); send_byte(8'hBF);
      for (int k = 0; k < 8; k++) recv_byte(bv[k]);
      tx_end();
      check("R11 sec", bv[0], 8'h00); check("R7 hour wrap", bv[2], 8'h00);
      check("R8 date wrap", bv[3], 8'h01);
      check("R8 month", bv[4], to_bcd(m == 12 ? 1 : m + 1));
      check("R9 weekday wrap", bv[5], 8'h01);
      check("R8 year", bv[6], (m == 12) ? 8'h22 : 8'h21);
      check("R10 ctrl last", bv[7], 8'h00);
    end

    // R8: leap sweep over every year, and mid-month increment
    for (int y = 0; y < 100; y++) begin
      burst_wr(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, to_bcd(y));
      pulse_tick();
      rd_reg(6'h03, v); check("R8 feb end", v, (y % 4 == 0) ? 8'h29 : 8'h01);
      if (y == 99) begin
        rd_reg(6'h05, v); check("R9 weekday inc", v, 8'h04);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule